// File: doc/BRIEF.md
# Up-counting timer with software event generation

The block is an up-counting timer reached through a simple 32-bit register bus. A prescaler divides the clock into ticks. The counter advances once per tick while it is enabled and returns to zero once it has reached the auto-reload limit. Each such wrap is an update event. Software can also force an update through a write-only event register. That register fires a one-cycle strobe and always reads back as zero.

An update raises a pending flag. Software clears the flag by writing 0 to it; writing 1 leaves it alone. The flag drives the interrupt request when the update interrupt is enabled. The auto-reload limit can be buffered: in that mode a new value waits in a preload register until the next update. A registered trigger output reports either update events, forced updates only, or the enable level, as the master-mode field selects.

The bus is a single-cycle interface. A write takes effect at the clock edge where `req_i` and `we_i` are both high. Read data is combinational from `addr_i`. A forced update works even while the counter is stopped, so software can load the limit and clear the counter before it starts.

Top module: `tmr_evtgen`

## Requirements
- R1: After reset every register reads 0, except auto-reload (byte address 0x2C), which reads all ones in its CNT_W bits. `irq_o` and `trgo_o` are low.
- R2: These are plain read/write storage: control 1 (0x00) bits 0 and 7, control 2 (0x04) bits 6:4, slave mode (0x08) bits 2:0, interrupt enable (0x0C) bit 0, and capture/compare mode 1 (0x18) bits 1:0. All other bits of these registers read 0.
- R3: The event register at 0x14 always reads 0. A write with bit 0 set forces one update event, lasting one cycle, at that write's clock edge.
- R4: A forced update sets the pending flag (status 0x10 bit 0) even when the enable bit (control 1 bit 0) is clear. It also clears the counter and the prescaler count, and copies the preload auto-reload value into the active limit.
- R5: Writing 1 to status bit 0 keeps its value, and writing 0 clears it. An update in the same cycle as the clear wins.
- R6: `irq_o` is high exactly while interrupt-enable bit 0 and the pending flag are both 1.
- R7: While enabled, a tick occurs once every PSC+1 cycles, where PSC is the prescaler register at 0x28. On each tick the counter (0x24) increments. A tick that finds the counter at or above the active limit sets it to 0 instead and produces an update event.
- R8: With control 1 bit 7 set, an auto-reload write only changes the preload value, and the active limit takes it at the next update. With the bit clear, the write changes both at once. Reads of 0x2C return the preload value.
- R9: A counter write takes effect at its clock edge whether or not the counter is running, and it overrides that cycle's counting.
- R10: `trgo_o` is registered and is driven by control 2 bits 6:4. Code 010 gives a one-cycle pulse in the cycle after each update event. Code 000 gives a pulse only after forced updates. Code 001 follows the enable bit one cycle late. Every other code keeps the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when high |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Update interrupt request |
| trgo_o | output | 1 | Selected trigger output |

## Verification
The hardest states to reach are an update that lands on the same edge as another register effect: a wrap that falls on a counter write, and a buffered limit that must not take effect until the wrap after next. The bench stops the counter, forces an update to zero the counter and prescaler, and then enables counting on a known edge. From there every later wrap falls on an edge it can count, and it writes the counter or auto-reload value on a chosen cycle. A counter value written above the limit shows that the wrap uses an at-or-above comparison.

// File: rtl/tmr_evtgen_pkg.sv
package tmr_evtgen_pkg;
  localparam int DW = 32;

  localparam int A_CTL1 = 'h00;
  localparam int A_CTL2 = 'h04;
  localparam int A_SLV  = 'h08;
  localparam int A_IEN  = 'h0C;
  localparam int A_STS  = 'h10;
  localparam int A_EVT  = 'h14;
  localparam int A_CCM1 = 'h18;
  localparam int A_CNT  = 'h24;
  localparam int A_PSC  = 'h28;
  localparam int A_ARR  = 'h2C;

  typedef enum logic [2:0] {
    TRG_FORCE = 3'b000,
    TRG_RUN   = 3'b001,
    TRG_UPD   = 3'b010
  } trg_sel_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_evtgen_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              upd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [CNT_W-1:0]  arr_i,
  output logic              run_o,
  output logic              buf_o,
  output logic [2:0]        trg_sel_o,
  output logic              ien_o,
  output logic              sts_o,
  output logic              force_o,
  output logic              cnt_we_o,
  output logic              psc_we_o,
  output logic              arr_we_o
);
  logic       wr;
  logic [2:0] slv_q;
  logic [1:0] ccm_q;

  assign wr       = req_i & we_i;
  assign force_o  = wr && addr_i == ADDR_W'(A_EVT) && wdata_i[0];
  assign cnt_we_o = wr && addr_i == ADDR_W'(A_CNT);
  assign psc_we_o = wr && addr_i == ADDR_W'(A_PSC);
  assign arr_we_o = wr && addr_i == ADDR_W'(A_ARR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o     <= 1'b0;
      buf_o     <= 1'b0;
      trg_sel_o <= '0;
      slv_q     <= '0;
      ien_o     <= 1'b0;
      ccm_q     <= '0;
    end else if (wr) begin
      if (addr_i == ADDR_W'(A_CTL1)) begin
        run_o <= wdata_i[0];
        buf_o <= wdata_i[7];
      end
      if (addr_i == ADDR_W'(A_CTL2)) trg_sel_o <= wdata_i[6:4];
      if (addr_i == ADDR_W'(A_SLV))  slv_q     <= wdata_i[2:0];
      if (addr_i == ADDR_W'(A_IEN))  ien_o     <= wdata_i[0];
      if (addr_i == ADDR_W'(A_CCM1)) ccm_q     <= wdata_i[1:0];
    end
  end

  // set has priority over a software clear; writing 1 keeps the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 sts_o <= 1'b0;
    else if (upd_i)                              sts_o <= 1'b1;
    else if (wr && addr_i == ADDR_W'(A_STS))     sts_o <= sts_o & wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CTL1): begin rdata_o[0] = run_o; rdata_o[7] = buf_o; end
      ADDR_W'(A_CTL2): rdata_o[6:4] = trg_sel_o;
      ADDR_W'(A_SLV):  rdata_o[2:0] = slv_q;
      ADDR_W'(A_IEN):  rdata_o[0]   = ien_o;
      ADDR_W'(A_STS):  rdata_o[0]   = sts_o;
      ADDR_W'(A_CCM1): rdata_o[1:0] = ccm_q;
      ADDR_W'(A_CNT):  rdata_o      = DW'(cnt_i);
      ADDR_W'(A_PSC):  rdata_o      = DW'(psc_i);
      ADDR_W'(A_ARR):  rdata_o      = DW'(arr_i);
      default:         rdata_o      = '0;
    endcase
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_evtgen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             buf_i,
  input  logic             force_i,
  input  logic             cnt_we_i,
  input  logic             psc_we_i,
  input  logic             arr_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             upd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PSC_W-1:0] psc_o,
  output logic [CNT_W-1:0] arr_pre_o,
  output logic [CNT_W-1:0] arr_act_o
);
  logic [PSC_W-1:0] div_q;
  logic             tick, wrap;

  assign tick  = run_i && (div_q == psc_o);
  assign wrap  = tick && (cnt_o >= arr_act_o);
  assign upd_o = force_i | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      psc_o     <= '0;
      cnt_o     <= '0;
      arr_pre_o <= '1;
      arr_act_o <= '1;
    end else begin
      if (psc_we_i) psc_o <= wdata_i[PSC_W-1:0];

      if (force_i)    div_q <= '0;
      else if (run_i) div_q <= tick ? '0 : div_q + 1'b1;

      if (cnt_we_i)     cnt_o <= wdata_i[CNT_W-1:0];
      else if (force_i) cnt_o <= '0;
      else if (tick)    cnt_o <= wrap ? '0 : cnt_o + 1'b1;

      if (arr_we_i) arr_pre_o <= wdata_i[CNT_W-1:0];

      if (arr_we_i && !buf_i) arr_act_o <= wdata_i[CNT_W-1:0];
      else if (upd_o)         arr_act_o <= arr_pre_o;
    end
  end
endmodule

// File: rtl/tmr_trig.sv
module tmr_trig
  import tmr_evtgen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] trg_sel_i,
  input  logic       force_i,
  input  logic       upd_i,
  input  logic       run_i,
  output logic       trgo_o
);
  logic nxt;

  always_comb begin
    case (trg_sel_e'(trg_sel_i))
      TRG_FORCE: nxt = force_i;
      TRG_RUN:   nxt = run_i;
      TRG_UPD:   nxt = upd_i;
      default:   nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trgo_o <= 1'b0;
    else         trgo_o <= nxt;
  end
endmodule

// File: rtl/tmr_evtgen.sv
module tmr_evtgen
  import tmr_evtgen_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              trgo_o
);
  logic             run, arr_buf, ien_q, sts_q, force_upd, upd;
  logic             cnt_we, psc_we, arr_we;
  logic [2:0]       trg_sel;
  logic [CNT_W-1:0] cnt_q, arr_pre, arr_act;
  logic [PSC_W-1:0] psc_q;

  tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .upd_i(upd), .cnt_i(cnt_q), .psc_i(psc_q), .arr_i(arr_pre),
    .run_o(run), .buf_o(arr_buf), .trg_sel_o(trg_sel), .ien_o(ien_q),
    .sts_o(sts_q), .force_o(force_upd), .cnt_we_o(cnt_we),
    .psc_we_o(psc_we), .arr_we_o(arr_we)
  );

  tmr_count #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_count (
    .clk_i, .rst_ni, .run_i(run), .buf_i(arr_buf), .force_i(force_upd),
    .cnt_we_i(cnt_we), .psc_we_i(psc_we), .arr_we_i(arr_we),
    .wdata_i, .upd_o(upd), .cnt_o(cnt_q), .psc_o(psc_q),
    .arr_pre_o(arr_pre), .arr_act_o(arr_act)
  );

  tmr_trig u_trig (
    .clk_i, .rst_ni, .trg_sel_i(trg_sel), .force_i(force_upd),
    .upd_i(upd), .run_i(run), .trgo_o
  );

  assign irq_o = ien_q & sts_q;
endmodule

// File: rtl/tmr_evtgen_chk.sv
module tmr_evtgen_chk
  import tmr_evtgen_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_lo,
  input logic [31:0]       rdata_o,
  input logic              trgo_o,
  input logic              upd,
  input logic              sts_q,
  input logic              arr_buf,
  input logic [2:0]        trg_sel,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  arr_act
);
  logic wr_evt1, wr_sts1, wr_arr;
  assign wr_evt1 = req_i && we_i && addr_i == ADDR_W'(A_EVT) && wdata_lo[0];
  assign wr_sts1 = req_i && we_i && addr_i == ADDR_W'(A_STS) && wdata_lo[0];
  assign wr_arr  = req_i && we_i && addr_i == ADDR_W'(A_ARR);

  p_evt_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(A_EVT) |-> rdata_o == '0);
  p_force_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt1 |=> sts_q);
  p_force_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt1 |=> cnt_q == '0);
  p_sts_w1_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts1 && !upd) |=> sts_q == $past(sts_q));
  p_arr_direct_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_arr && !arr_buf) |=> arr_act == $past(wdata_lo));
  p_arr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_arr && arr_buf && !upd) |=> $stable(arr_act));
  p_trg_upd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trg_sel == 3'b010 && upd) |=> trgo_o);
  p_trg_rsvd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trg_sel > 3'b010) |=> !trgo_o);
endmodule

bind tmr_evtgen tmr_evtgen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_lo(wdata_i[15:0]), .rdata_o(rdata_o), .trgo_o(trgo_o), .upd(upd),
  .sts_q(sts_q), .arr_buf(arr_buf), .trg_sel(trg_sel), .cnt_q(cnt_q),
  .arr_act(arr_act)
);

// File: tb/sim_tmr_evtgen.sv
`timescale 1ns/1ps
module sim_tmr_evtgen;
  localparam logic [7:0] CTL1 = 8'h00, CTL2 = 8'h04, SLV = 8'h08, IEN = 8'h0C,
                         STS = 8'h10, EVT = 8'h14, CCM1 = 8'h18, CNT = 8'h24,
                         PSC = 8'h28, ARR = 8'h2C;

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, trgo;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tmr_evtgen u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .trgo_o(trgo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #0.2;
    chk(tag, rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 trgo", {31'b0, trgo}, 0);
    chk_rd("R1 ctl1", CTL1, 0);
    chk_rd("R1 cnt", CNT, 0);
    chk_rd("R1 arr", ARR, 32'h0000_FFFF);
  endtask

  task automatic t_regs;
    wr(CTL2, 32'hFFFF_FFFF); chk_rd("R2 ctl2", CTL2, 32'h70);
    wr(SLV, 32'hFFFF_FFFD);  chk_rd("R2 slv", SLV, 32'h5);
    wr(CCM1, 32'hFFFF_FFFF); chk_rd("R2 ccm1", CCM1, 32'h3);
    wr(CTL1, 32'hFFFF_FF7E); chk_rd("R2 ctl1 mask", CTL1, 32'h0);
    wr(EVT, 32'h0);          chk_rd("R3 evt reads zero", EVT, 0);
    wr(CTL2, 32'h20);
  endtask

  task automatic t_force;
    wr(CNT, 7); chk_rd("R9 cnt write stopped", CNT, 7);
    wr(IEN, 1); chk("R6 irq idle", {31'b0, irq}, 0);
    wr(EVT, 1);
    chk("R10 trgo upd pulse", {31'b0, trgo}, 1);
    chk("R6 irq on pend", {31'b0, irq}, 1);
    chk_rd("R4 pend while stopped", STS, 1);
    chk_rd("R4 cnt cleared", CNT, 0);
    chk_rd("R3 evt read after fire", EVT, 0);
    cyc(1);
    chk("R3 one-cycle event", {31'b0, trgo}, 0);
    chk_rd("R4 stays stopped", CNT, 0);
  endtask

  task automatic t_status;
    wr(STS, 1); chk_rd("R5 write 1 keeps", STS, 1);
    chk("R6 irq kept", {31'b0, irq}, 1);
    wr(STS, 0); chk_rd("R5 write 0 clears", STS, 0);
    chk("R6 irq drops", {31'b0, irq}, 0);
    wr(STS, 1); chk_rd("R5 write 1 on clear", STS, 0);
    wr(IEN, 0);
  endtask

  task automatic t_count;
    wr(ARR, 3);
    wr(CTL1, 1);
    cyc(3);
    chk_rd("R7 cnt at limit", CNT, 3);
    chk_rd("R7 no early update", STS, 0);
    cyc(1);
    chk("R10 pulse on wrap", {31'b0, trgo}, 1);
    chk_rd("R7 wrap to 0", CNT, 0);
    chk_rd("R7 wrap sets pend", STS, 1);
    chk("R6 irq masked", {31'b0, irq}, 0);
    wr(CTL1, 0); wr(STS, 0);
  endtask

  task automatic t_cntwr;
    wr(CNT, 32'hFFFF); chk_rd("R9 cnt above limit", CNT, 32'hFFFF);
    wr(CTL1, 1);
    chk_rd("R9 no update yet", STS, 0);
    cyc(1);
    chk_rd("R7 wrap from above limit", CNT, 0);
    chk_rd("R9 immediate update", STS, 1);
    wr(CNT, 32'h10);
    chk_rd("R9 write beats counting", CNT, 32'h10);
    wr(CTL1, 0); wr(STS, 0);
  endtask

  task automatic t_prescale;
    wr(PSC, 2); wr(ARR, 100); wr(EVT, 1); wr(STS, 0);
    chk_rd("R4 force clears cnt", CNT, 0);
    wr(CTL1, 1);
    cyc(2);
    chk_rd("R7 prescale hold", CNT, 0);
    cyc(1);
    chk_rd("R7 first tick", CNT, 1);
    cyc(3);
    chk_rd("R7 second tick", CNT, 2);
    wr(CTL1, 0); wr(PSC, 0);
  endtask

  task automatic t_preload;
    wr(ARR, 3); wr(CTL1, 32'h80); wr(EVT, 1); wr(STS, 0);
    wr(ARR, 6);
    chk_rd("R8 reads preload", ARR, 6);
    wr(CTL1, 32'h81);
    cyc(4);
    chk_rd("R8 old limit active", STS, 1);
    chk_rd("R8 wrap at old limit", CNT, 0);
    wr(STS, 0);
    cyc(4);
    chk_rd("R8 new limit reached", CNT, 6);
    chk_rd("R8 no wrap below new", STS, 0);
    cyc(1);
    chk_rd("R8 wrap at new limit", STS, 1);
    wr(CTL1, 0); wr(STS, 0);
  endtask

  task automatic t_trig;
    int hits;
    wr(CTL2, 32'h00); wr(ARR, 1);
    wr(EVT, 1);
    chk("R10 code 000 on force", {31'b0, trgo}, 1);
    wr(STS, 0);
    wr(CTL2, 32'h10);
    chk("R10 code 001 idle", {31'b0, trgo}, 0);
    wr(CTL1, 1);
    chk("R10 code 001 lags", {31'b0, trgo}, 0);
    cyc(1);
    chk("R10 code 001 follows", {31'b0, trgo}, 1);
    wr(CTL2, 32'h00);
    hits = 0;
    for (int i = 0; i < 6; i++) begin cyc(1); if (trgo) hits++; end
    chk("R10 code 000 ignores wraps", hits, 0);
    chk_rd("R10 wraps happened", STS, 1);
    wr(CTL2, 32'h30);
    hits = 0;
    for (int i = 0; i < 6; i++) begin cyc(1); if (trgo) hits++; end
    chk("R10 reserved code low", hits, 0);
    wr(CTL1, 0); wr(STS, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_force;
    t_status;
    t_count;
    t_cntwr;
    t_prescale;
    t_preload;
    t_trig;
    done = 1'b1;
    summary;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary;
    end
  end
endmodule